// File: doc/BRIEF.md
# Scatter-Gather Task Sequencer

This block works through a list of transfer tasks that sit in memory, one task at a time, over a single memory master port. A built-in loader stage first copies the next four-word task record from the task table into a fixed alternate slot in memory. While doing so it latches the record's source end, destination end and control word. The beat engine then moves that task's N words, and the loader comes back for the next record until the task count it was started with runs out. Only then does the block raise a one-cycle completion pulse.

The block has two run modes, picked by `mode_mem` at the starting request. In memory mode one request runs the whole list, with no further requests needed. In peripheral mode the block halts after every slice and waits for a new request. A slice is either one task copy or up to 2^R transfers of the current task, where R comes from that task's own control word. The memory is word addressed and has one cycle of read latency. A transfer reads in one cycle and writes the returned word in the next.

Top module: `sg_task_sequencer`

## Requirements
- R1: During and right after reset, `mem_rd`, `mem_wr` and `done` are low. A read and a write are never issued in the same cycle.
- R2: A copy step makes four read/write pairs. Word k (0..3) of the task record is read from table pointer + k, and in the next cycle it is written to `cfg_alt` + k with the data read.
- R3: A task with source end S, destination end D and count N reads S-N+1 up to S in ascending order. Each word is written to the matching address from D-N+1 up to D in the cycle after its read. Nothing past D is written.
- R4: Control word (record word 2): bits [3:0] hold R, bits [13:4] hold N-1, and bits [31:14] are ignored. Record word 3 is copied to the slot but otherwise unused.
- R5: Tasks run in table order, with the table pointer advancing by four words per task, until `cfg_tasks` tasks have run. Each task uses its own R and N.
- R6: In memory mode, one request runs the whole list. `done` is high in cycle 8T + 2·ΣN + 1 after the clock edge that samples the request.
- R7: In peripheral mode, each task copy and each slice of up to 2^R transfers waits for its own request, and the last slice of a task may be short. No memory access happens while waiting.
- R8: `done` is a single-cycle pulse given once per list, after the last transfer of the last task and never after a copy step. No memory access happens in that cycle.
- R9: A request with `cfg_tasks` = 0 gives `done` in the cycle after the sampling edge, with no memory access.
- R10: A request seen while a copy or a slice is running has no effect.
- R11: The mode is sampled at the starting request. Changing `mode_mem` during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Transfer request |
| mode_mem | input | 1 | 1: memory mode, 0: peripheral mode |
| cfg_table | input | AW | Word address of the first task record |
| cfg_alt | input | AW | Word address of the alternate slot |
| cfg_tasks | input | TW | Number of tasks in the list |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | List-complete pulse |

## Verification
In memory mode, `done` is due 8T + 2·ΣN + 1 cycles after the edge that samples the request, or 1 cycle after it for an empty list. The bench counts falling edges from that sampling edge and compares the count when `done` first appears with that figure. In peripheral mode the exact cycle depends on request spacing, so requests are spaced well beyond the longest slice. The bench checks that `done` is still absent before the last request and present once within a bounded wait after it. Memory contents, write counts and the alternate slot are inspected only once the pulse has passed.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  localparam int WORD_W     = 32;
  localparam int TASK_WORDS = 4;
  localparam int CTL_W      = 14;
  localparam int RF_W       = 4;
  localparam int NF_W       = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_CRD, ST_CWR, ST_XRD, ST_XWR, ST_DONE
  } sgs_state_t;

  function automatic logic [RF_W-1:0] ctl_r(input logic [CTL_W-1:0] c);
    return c[RF_W-1:0];
  endfunction

  function automatic logic [NF_W-1:0] ctl_nm1(input logic [CTL_W-1:0] c);
    return c[RF_W +: NF_W];
  endfunction

  // last transfer of a 2^r slice; slices wider than any task never end early
  function automatic logic slice_last(input logic [NF_W-1:0] cnt,
                                      input logic [RF_W-1:0] r);
    if (int'(r) >= NF_W) return 1'b0;
    return cnt == ((NF_W'(1) << r) - NF_W'(1));
  endfunction
endpackage

// File: rtl/sgs_loader.sv
module sgs_loader
  import sgs_pkg::*;
#(
  parameter int AW = 8,
  parameter int TW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     cfg_table,
  input  logic [AW-1:0]     cfg_alt,
  input  logic [TW-1:0]     cfg_tasks,
  input  logic              word_step,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [AW-1:0]     rd_addr,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     alt_base,
  output logic              copy_last,
  output logic              more_tasks,
  output logic [AW-1:0]     src_end,
  output logic [AW-1:0]     dst_end,
  output logic [CTL_W-1:0]  ctl
);
  logic [AW-1:0] ptr_q, alt_q;
  logic [TW-1:0] left_q;
  logic [1:0]    k_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0; alt_q <= '0; left_q <= '0; k_q <= '0;
      src_end <= '0; dst_end <= '0; ctl <= '0;
    end else if (start) begin
      ptr_q  <= cfg_table;
      alt_q  <= cfg_alt;
      left_q <= cfg_tasks;
      k_q    <= '0;
    end else if (word_step) begin
      case (k_q)
        2'd0:    src_end <= mem_rdata[AW-1:0];
        2'd1:    dst_end <= mem_rdata[AW-1:0];
        2'd2:    ctl     <= mem_rdata[CTL_W-1:0];
        default: ;
      endcase
      k_q <= k_q + 2'd1;
      if (k_q == 2'd3) begin
        ptr_q  <= ptr_q + AW'(TASK_WORDS);
        left_q <= left_q - TW'(1);
      end
    end
  end

  assign rd_addr    = ptr_q + AW'(k_q);
  assign wr_addr    = alt_q + AW'(k_q);
  assign alt_base   = alt_q;
  assign copy_last  = (k_q == 2'd3);
  assign more_tasks = (left_q != '0);
endmodule

// File: rtl/sgs_beat.sv
module sgs_beat
  import sgs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    src_end,
  input  logic [AW-1:0]    dst_end,
  input  logic [CTL_W-1:0] ctl,
  input  logic             step,
  output logic [AW-1:0]    src_addr,
  output logic [AW-1:0]    dst_addr,
  output logic             xfer_last,
  output logic             slice_end
);
  logic [NF_W-1:0] rem_q, sl_q;
  logic [RF_W-1:0] r_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_addr <= '0; dst_addr <= '0; rem_q <= '0; sl_q <= '0; r_q <= '0;
    end else if (load) begin
      src_addr <= src_end - AW'(ctl_nm1(ctl));
      dst_addr <= dst_end - AW'(ctl_nm1(ctl));
      rem_q    <= ctl_nm1(ctl);
      sl_q     <= '0;
      r_q      <= ctl_r(ctl);
    end else if (step) begin
      src_addr <= src_addr + AW'(1);
      dst_addr <= dst_addr + AW'(1);
      rem_q    <= rem_q - NF_W'(1);
      sl_q     <= slice_last(sl_q, r_q) ? '0 : sl_q + NF_W'(1);
    end
  end

  assign xfer_last = (rem_q == '0);
  assign slice_end = slice_last(sl_q, r_q);
endmodule

// File: rtl/sgs_fsm.sv
module sgs_fsm
  import sgs_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          mode_mem,
  input  logic [TW-1:0] cfg_tasks,
  input  logic          copy_last,
  input  logic          more_tasks,
  input  logic          xfer_last,
  input  logic          slice_end,
  output sgs_state_t    state,
  output logic          start,
  output logic          run_mem
);
  sgs_state_t nxt;
  logic       next_copy_q;

  assign start = (state == ST_IDLE) && req;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (req) nxt = (cfg_tasks == '0) ? ST_DONE : ST_CRD;
      ST_CRD:  nxt = ST_CWR;
      ST_CWR:  if (!copy_last) nxt = ST_CRD;
               else nxt = run_mem ? ST_XRD : ST_WAIT;
      ST_XRD:  nxt = ST_XWR;
      ST_XWR:  if (xfer_last) begin
                 if (!more_tasks) nxt = ST_DONE;
                 else nxt = run_mem ? ST_CRD : ST_WAIT;
               end else if (slice_end && !run_mem) nxt = ST_WAIT;
               else nxt = ST_XRD;
      ST_WAIT: if (req) nxt = next_copy_q ? ST_CRD : ST_XRD;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; run_mem <= 1'b0; next_copy_q <= 1'b0;
    end else begin
      state <= nxt;
      if (start) run_mem <= mode_mem;
      if (state == ST_CWR) next_copy_q <= 1'b0;
      if (state == ST_XWR && xfer_last) next_copy_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sg_task_sequencer.sv
module sg_task_sequencer
  import sgs_pkg::*;
#(
  parameter int AW = 8,
  parameter int TW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              mode_mem,
  input  logic [AW-1:0]     cfg_table,
  input  logic [AW-1:0]     cfg_alt,
  input  logic [TW-1:0]     cfg_tasks,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done
);
  sgs_state_t       state;
  logic             start, run_mem;
  logic [AW-1:0]    ld_rd, ld_wr, ld_alt, t_src_end, t_dst_end, x_src, x_dst;
  logic [CTL_W-1:0] t_ctl;
  logic             copy_last, more_tasks, xfer_last, slice_end;

  // named internal events for the checker
  logic ev_copy_wr, ev_copy_end, ev_xfer_wr, ev_slice_end;
  assign ev_copy_wr   = (state == ST_CWR);
  assign ev_copy_end  = ev_copy_wr && copy_last;
  assign ev_xfer_wr   = (state == ST_XWR);
  assign ev_slice_end = ev_xfer_wr && (slice_end || xfer_last);

  sgs_fsm #(.TW(TW)) u_fsm (
    .clk, .rst_n, .req, .mode_mem, .cfg_tasks,
    .copy_last, .more_tasks, .xfer_last, .slice_end,
    .state, .start, .run_mem
  );

  sgs_loader #(.AW(AW), .TW(TW)) u_loader (
    .clk, .rst_n, .start, .cfg_table, .cfg_alt, .cfg_tasks,
    .word_step(ev_copy_wr), .mem_rdata,
    .rd_addr(ld_rd), .wr_addr(ld_wr), .alt_base(ld_alt),
    .copy_last, .more_tasks,
    .src_end(t_src_end), .dst_end(t_dst_end), .ctl(t_ctl)
  );

  sgs_beat #(.AW(AW)) u_beat (
    .clk, .rst_n, .load(ev_copy_end),
    .src_end(t_src_end), .dst_end(t_dst_end), .ctl(t_ctl),
    .step(ev_xfer_wr),
    .src_addr(x_src), .dst_addr(x_dst), .xfer_last, .slice_end
  );

  assign mem_rd = (state == ST_CRD) || (state == ST_XRD);
  assign mem_wr = ev_copy_wr || ev_xfer_wr;
  assign done   = (state == ST_DONE);

  always_comb begin
    case (state)
      ST_CRD:  mem_addr = ld_rd;
      ST_CWR:  mem_addr = ld_wr;
      ST_XRD:  mem_addr = x_src;
      ST_XWR:  mem_addr = x_dst;
      default: mem_addr = '0;
    endcase
  end

  assign mem_wdata = mem_wr ? mem_rdata : '0;
endmodule

// File: rtl/sgs_chk.sv
module sgs_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] ld_alt,
  input logic          ev_copy_wr,
  input logic          ev_copy_end,
  input logic          ev_slice_end,
  input logic          run_mem
);
  // R1
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(mem_rd || mem_wr));
  // R2
  copy_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_copy_wr |-> (AW'(mem_addr - ld_alt) < AW'(4)));
  // R7
  per_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_slice_end || ev_copy_end) && !run_mem) |=> !(mem_rd || mem_wr));
endmodule

bind sg_task_sequencer sgs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .done(done),
  .mem_addr(mem_addr), .ld_alt(ld_alt), .ev_copy_wr(ev_copy_wr),
  .ev_copy_end(ev_copy_end), .ev_slice_end(ev_slice_end), .run_mem(run_mem)
);

// File: tb/test_sg_task_sequencer.sv
`timescale 1ns/1ps
module test_sg_task_sequencer;
  localparam int AW = 8;
  localparam int TW = 6;
  localparam int GAP = 30;
  localparam logic [AW-1:0] TBL = 8'h10;
  localparam logic [AW-1:0] ALT = 8'h30;
  // {mode, T, n0, n1, n2, r0, r1, r2}
  localparam logic [26:0] VEC [6] = '{
    {1'b1, 2'd3, 4'd2, 4'd4, 4'd2, 4'd1, 4'd1, 4'd1},
    {1'b0, 2'd3, 4'd2, 4'd4, 4'd2, 4'd1, 4'd1, 4'd1},
    {1'b1, 2'd1, 4'd8, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    {1'b0, 2'd2, 4'd5, 4'd3, 4'd0, 4'd1, 4'd2, 4'd0},
    {1'b0, 2'd1, 4'd6, 4'd0, 4'd0, 4'd4, 4'd0, 4'd0},
    {1'b1, 2'd2, 4'd1, 4'd7, 4'd0, 4'd3, 4'd0, 4'd0}
  };

  logic clk = 0, rst_n = 0, req = 0, mode_mem = 0;
  logic [AW-1:0] cfg_table = TBL, cfg_alt = ALT;
  logic [TW-1:0] cfg_tasks = '0;
  logic mem_rd, mem_wr, done;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] mem [256];

  int n_chk = 0, n_fail = 0, done_cnt = 0, wr_cnt = 0, rd_cnt = 0;
  int tn [3], tr [3];
  int cur_t;

  always #4 clk = ~clk;

  sg_task_sequencer #(.AW(AW), .TW(TW)) i_sg_task_sequencer (
    .clk, .rst_n, .req, .mode_mem, .cfg_table, .cfg_alt, .cfg_tasks,
    .mem_rd, .mem_wr, .mem_addr, .mem_wdata, .mem_rdata, .done
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (mem_wr) wr_cnt++;
    if (mem_rd) rd_cnt++;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] srcval(input int v, input int i, input int j);
    return {8'(v), 8'(i), 8'(j), 8'h5A};
  endfunction

  function automatic logic [31:0] word_of(input int i, input int k);
    case (k)
      0: return 32'(8'h40 + 16 * i + tn[i] - 1);
      1: return 32'(8'h80 + 16 * i + tn[i] - 1);
      // R4: junk in bits [31:14] must be ignored
      2: return 32'hF0F0_C000 | 32'((tn[i] - 1) << 4) | 32'(tr[i]);
      default: return 32'hDEAD_0000 | 32'(i);
    endcase
  endfunction

  task automatic prepare(input int v);
    for (int a = 0; a < 256; a++) mem[a] = 32'h0;
    for (int i = 0; i < cur_t; i++) begin
      for (int k = 0; k < 4; k++) mem[int'(TBL) + 4 * i + k] = word_of(i, k);
      for (int j = 0; j < 16; j++) mem[8'h40 + 16 * i + j] = srcval(v, i, j);
    end
    cfg_tasks = TW'(cur_t);
    done_cnt = 0; wr_cnt = 0; rd_cnt = 0;
  endtask

  function automatic int sum_n();
    int s = 0;
    for (int i = 0; i < cur_t; i++) s += tn[i];
    return s;
  endfunction

  function automatic int per_reqs();
    int s = cur_t;
    for (int i = 0; i < cur_t; i++) s += (tn[i] + (1 << tr[i]) - 1) >> tr[i];
    return s;
  endfunction

  task automatic run_mem(input int exp_lat, input bit inject, input string tag);
    int c = 0;
    @(negedge clk); req = 1;
    do begin
      @(negedge clk); c++;
      req = inject && (c == 4);
    end while (!done && c < 3000);
    req = 0;
    chk(c == exp_lat, {tag, " done latency"}, c, exp_lat);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
  endtask

  task automatic run_per(input int reqs);
    int w = 0;
    for (int q = 0; q < reqs; q++) begin
      if (q == reqs - 1) chk(done_cnt == 0, "R7 no done before last request", done_cnt, 0);
      @(negedge clk); req = 1;
      @(negedge clk); req = 0;
      repeat (GAP) @(negedge clk);
    end
    while (done_cnt == 0 && w < 100) begin @(negedge clk); w++; end
    chk(done_cnt == 1, "R8 R7 done once after last request", done_cnt, 1);
  endtask

  task automatic verify(input int v);
    for (int i = 0; i < cur_t; i++) begin
      for (int j = 0; j < tn[i]; j++)
        chk(mem[8'h80 + 16 * i + j] == srcval(v, i, j), "R3 R5 destination word",
            int'(mem[8'h80 + 16 * i + j]), int'(srcval(v, i, j)));
      chk(mem[8'h80 + 16 * i + tn[i]] == 0, "R3 nothing past destination end",
          int'(mem[8'h80 + 16 * i + tn[i]]), 0);
    end
    for (int k = 0; k < 4; k++)
      chk(mem[int'(ALT) + k] == word_of(cur_t - 1, k), "R2 R4 alternate slot word",
          int'(mem[int'(ALT) + k]), int'(word_of(cur_t - 1, k)));
    chk(wr_cnt == 4 * cur_t + sum_n(), "R2 R3 write count", wr_cnt, 4 * cur_t + sum_n());
  endtask

  task automatic load_vec(input int v);
    logic [26:0] e = VEC[v];
    mode_mem = e[26];
    cur_t = int'(e[25:24]);
    tn[0] = int'(e[23:20]); tn[1] = int'(e[19:16]); tn[2] = int'(e[15:12]);
    tr[0] = int'(e[11:8]);  tr[1] = int'(e[7:4]);   tr[2] = int'(e[3:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mem_rd && !mem_wr && !done, "R1 outputs idle in reset", {mem_rd, mem_wr, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_rd && !mem_wr && !done, "R1 outputs idle after reset", {mem_rd, mem_wr, done}, 0);

    for (int v = 0; v < 6; v++) begin
      load_vec(v);
      prepare(v);
      if (mode_mem) run_mem(8 * cur_t + 2 * sum_n() + 1, 1'b0, "R6");
      else run_per(per_reqs());
      verify(v);
    end

    // R9: empty list
    cur_t = 0; mode_mem = 1; prepare(9);
    run_mem(1, 1'b0, "R9");
    chk(rd_cnt == 0 && wr_cnt == 0, "R9 no memory access", rd_cnt + wr_cnt, 0);

    // R10: extra request mid-run ignored
    load_vec(0); prepare(10);
    run_mem(8 * cur_t + 2 * sum_n() + 1, 1'b1, "R10");
    verify(10);

    // R11: mode flipped after the start is ignored
    load_vec(3); prepare(11);
    @(negedge clk); req = 1;
    @(negedge clk); req = 0; mode_mem = 1;
    repeat (60) @(negedge clk);
    chk(wr_cnt == 4 && done_cnt == 0, "R11 R7 run halts after copy", wr_cnt, 4);
    run_per(per_reqs() - 1);
    mode_mem = 0;
    verify(11);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule